// File: doc/BRIEF.md
# GPIO Port with Routed Line Interrupts

This block is a general-purpose I/O port of up to 32 lines. Software reaches it over a simple 32-bit register bus with an address, a write enable, write data and registered read data. Every line has its own output value and direction bit. The port reports pin values through a two-flop synchroniser. Each line can also detect a trigger condition and raise an interrupt.

A line's trigger is chosen by two bits, a polarity bit and an edge bit. Together they select active-low level, active-high level, falling edge or rising edge. A mask bit enables each line. A per-line byte in a routing map steers the line's interrupt to one of `NIRQ` interrupt output wires, or to none. Each output wire is the OR of every enabled, triggered line steered to it.

The per-line registers sit at word offsets 0x00 (synchronised input, read-only), 0x04 (output value), 0x08 (direction), 0x0C (mask), 0x10 (polarity) and 0x14 (edge select). The routing map starts at 0x20 and holds four lines per word. Bit n of each per-line register belongs to line n.

Top module: `gpio_irq_port`

## Requirements
- R1: After a synchronous reset, all registers hold zero. `pin_oe`, `pin_out`, `irq_out` and the read data are all zero.
- R2: A write to offset 0x04 or 0x08 sets `pin_out` or `pin_oe` to bits [NLINES-1:0] of the write data. The new value appears on the clock edge that takes the write, and `pin_out` changes at no other time.
- R3: A read of offset 0x00 returns `pin_in` as seen through a two-flop synchroniser. A write to offset 0x00 has no effect.
- R4: With edge bit 0, polarity 1 raises the routed output while the synchronised pin is 1, and polarity 0 raises it while the pin is 0. The output stays high while the level holds and appears three cycles after the pin changes.
- R5: With edge bit 1, polarity 1 detects a 0-to-1 change and polarity 0 detects a 1-to-0 change. Either one gives exactly one cycle of output, three cycles after the pin changes. A change in the other direction gives nothing.
- R6: A line whose mask bit is 0 never drives any interrupt output.
- R7: Line n is steered by the byte at bits [8*(n%4)+7 : 8*(n%4)] of the word at offset 0x20 + 4*(n/4). A byte value k below NIRQ selects `irq_out[k]`. A value of NIRQ or above leaves the line unrouted. A map change takes effect on the output one cycle after the write.
- R8: When several enabled lines are steered to the same output and trigger in the same cycle, the output is their OR, so simultaneous edges give one single-cycle pulse.
- R9: Read data is registered and returns one cycle after the address. Reads of per-line registers return zero above bit NLINES-1. Unused offsets (0x18, 0x1C, and map words past the last line) read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NLINES | Raw asynchronous pin values |
| pin_out | output | NLINES | Output value for each line |
| pin_oe | output | NLINES | Output enable for each line (1 = drive) |
| irq_out | output | NIRQ | Routed interrupt outputs |

## Verification
Two functions can meet in one cycle: an edge trigger on one line and a trigger on another line steered to the same or a different output. The bench provokes this by changing several pins in the same cycle. In one case two rising edges are routed to one shared output. In another, a rising edge and an active-high level go to separate outputs. The bench judges the result cycle by cycle: the shared output must pulse exactly once, and the level output must stay high after the edge pulse has ended.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // word indices (byte address >> 2)
  localparam int W_DIN  = 0;
  localparam int W_DOUT = 1;
  localparam int W_DIR  = 2;
  localparam int W_MASK = 3;
  localparam int W_POL  = 4;
  localparam int W_EDGE = 5;
  localparam int W_MAP0 = 8;

  localparam int LINES_PER_WORD = 4;
  localparam int MAP_BITS       = 8;

  // trigger decision for one line
  function automatic logic trig_hit(input logic pol, input logic edg,
                                    input logic cur, input logic prv);
    logic r;
    if (edg) r = pol ? (cur & ~prv) : (~cur & prv);
    else     r = pol ? cur : ~cur;
    return r;
  endfunction

endpackage

// File: rtl/gpio_bus_regs.sv
module gpio_bus_regs
  import gpio_irq_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int ADDR_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       we,
  input  logic [31:0]                wdata,
  input  logic [NLINES-1:0]          din_sync,
  output logic [NLINES-1:0]          dout_q,
  output logic [NLINES-1:0]          dir_q,
  output logic [NLINES-1:0]          mask_q,
  output logic [NLINES-1:0]          pol_q,
  output logic [NLINES-1:0]          edge_q,
  output logic [NLINES*MAP_BITS-1:0] map_q,
  output logic [31:0]                rdata
);

  localparam int MAP_WORDS = (NLINES + LINES_PER_WORD - 1) / LINES_PER_WORD;

  logic [ADDR_W-1:0] word;
  assign word = addr >> 2;

  function automatic logic hit_word(input logic [ADDR_W-1:0] w, input int idx);
    return w == ADDR_W'(idx);
  endfunction

  // per-line registers
  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      dir_q  <= '0;
      mask_q <= '0;
      pol_q  <= '0;
      edge_q <= '0;
    end else if (we) begin
      if (hit_word(word, W_DOUT)) dout_q <= wdata[NLINES-1:0];
      if (hit_word(word, W_DIR))  dir_q  <= wdata[NLINES-1:0];
      if (hit_word(word, W_MASK)) mask_q <= wdata[NLINES-1:0];
      if (hit_word(word, W_POL))  pol_q  <= wdata[NLINES-1:0];
      if (hit_word(word, W_EDGE)) edge_q <= wdata[NLINES-1:0];
    end
  end

  // routing map: one byte per line, four lines per word
  genvar gn;
  generate
    for (gn = 0; gn < NLINES; gn++) begin : g_map
      localparam int MW = W_MAP0 + gn / LINES_PER_WORD;
      localparam int MB = (gn % LINES_PER_WORD) * MAP_BITS;
      always_ff @(posedge clk) begin
        if (rst) map_q[gn*MAP_BITS +: MAP_BITS] <= '0;
        else if (we && hit_word(word, MW))
          map_q[gn*MAP_BITS +: MAP_BITS] <= wdata[MB +: MAP_BITS];
      end
    end
  endgenerate

  // read mux
  logic [31:0] rd_d;
  always_comb begin
    rd_d = '0;
    if (hit_word(word, W_DIN))       rd_d[NLINES-1:0] = din_sync;
    else if (hit_word(word, W_DOUT)) rd_d[NLINES-1:0] = dout_q;
    else if (hit_word(word, W_DIR))  rd_d[NLINES-1:0] = dir_q;
    else if (hit_word(word, W_MASK)) rd_d[NLINES-1:0] = mask_q;
    else if (hit_word(word, W_POL))  rd_d[NLINES-1:0] = pol_q;
    else if (hit_word(word, W_EDGE)) rd_d[NLINES-1:0] = edge_q;
    else begin
      for (int w = 0; w < MAP_WORDS; w++) begin
        if (hit_word(word, W_MAP0 + w)) begin
          for (int b = 0; b < LINES_PER_WORD; b++) begin
            if (w * LINES_PER_WORD + b < NLINES)
              rd_d[b*MAP_BITS +: MAP_BITS] =
                map_q[(w*LINES_PER_WORD + b)*MAP_BITS +: MAP_BITS];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_d;
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NLINES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] cur_q,
  output logic [NLINES-1:0] prv_q
);

  logic [NLINES-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      cur_q  <= '0;
      prv_q  <= '0;
    end else begin
      meta_q <= pin_in;
      cur_q  <= meta_q;
      prv_q  <= cur_q;
    end
  end

endmodule

// File: rtl/gpio_trig.sv
module gpio_trig
  import gpio_irq_pkg::*;
#(
  parameter int NLINES = 32
) (
  input  logic [NLINES-1:0] cur,
  input  logic [NLINES-1:0] prv,
  input  logic [NLINES-1:0] mask,
  input  logic [NLINES-1:0] pol,
  input  logic [NLINES-1:0] edg,
  output logic [NLINES-1:0] hit
);

  genvar gn;
  generate
    for (gn = 0; gn < NLINES; gn++) begin : g_line
      assign hit[gn] = mask[gn] & trig_hit(pol[gn], edg[gn], cur[gn], prv[gn]);
    end
  endgenerate

endmodule

// File: rtl/gpio_route.sv
module gpio_route
  import gpio_irq_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int NIRQ   = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NLINES-1:0]          hit,
  input  logic [NLINES*MAP_BITS-1:0] map,
  output logic [NIRQ-1:0]            irq_q
);

  logic [NIRQ-1:0] irq_d;

  genvar gk;
  generate
    for (gk = 0; gk < NIRQ; gk++) begin : g_out
      always_comb begin
        irq_d[gk] = 1'b0;
        for (int n = 0; n < NLINES; n++)
          if (hit[n] && (map[n*MAP_BITS +: MAP_BITS] == MAP_BITS'(gk)))
            irq_d[gk] = 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= irq_d;
  end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int NIRQ   = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] pin_out,
  output logic [NLINES-1:0] pin_oe,
  output logic [NIRQ-1:0]   irq_out
);

  initial begin
    if (NLINES < 1 || NLINES > 32) $error("NLINES out of range");
    if (NIRQ < 1 || NIRQ > 255)    $error("NIRQ out of range");
  end

  logic [NLINES-1:0]          cur, prv, mask, pol, edg, hit;
  logic [NLINES*MAP_BITS-1:0] map;

  gpio_in_sync #(.NLINES(NLINES)) u_sync (
    .clk(clk), .rst(rst), .pin_in(pin_in), .cur_q(cur), .prv_q(prv)
  );

  gpio_bus_regs #(.NLINES(NLINES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .din_sync(cur), .dout_q(pin_out), .dir_q(pin_oe), .mask_q(mask),
    .pol_q(pol), .edge_q(edg), .map_q(map), .rdata(bus_rdata)
  );

  gpio_trig #(.NLINES(NLINES)) u_trig (
    .cur(cur), .prv(prv), .mask(mask), .pol(pol), .edg(edg), .hit(hit)
  );

  gpio_route #(.NLINES(NLINES), .NIRQ(NIRQ)) u_route (
    .clk(clk), .rst(rst), .hit(hit), .map(map), .irq_q(irq_out)
  );

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_irq_pkg::*;
#(
  parameter int NLINES = 32,
  parameter int NIRQ   = 4,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [NLINES-1:0] pin_out,
  input logic [NLINES-1:0] pin_oe,
  input logic [NIRQ-1:0]   irq_out
);

  localparam logic [32:0] LMASK_W = (33'd1 << NLINES) - 33'd1;
  localparam logic [31:0] LMASK   = LMASK_W[31:0];

  logic [ADDR_W-1:0] word;
  assign word = bus_addr >> 2;

  logic wr_dout, wr_dir, wr_mask, rd_line, rd_gap;
  assign wr_dout = bus_we && word == ADDR_W'(W_DOUT);
  assign wr_dir  = bus_we && word == ADDR_W'(W_DIR);
  assign wr_mask = bus_we && word == ADDR_W'(W_MASK);
  assign rd_line = !bus_we && word <= ADDR_W'(W_EDGE);
  assign rd_gap  = !bus_we && (word == ADDR_W'(6) || word == ADDR_W'(7));

  // shadow of the mask register, rebuilt from bus writes
  logic [NLINES-1:0] mask_sh;
  always_ff @(posedge clk) begin
    if (rst) mask_sh <= '0;
    else if (wr_mask) mask_sh <= bus_wdata[NLINES-1:0];
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (irq_out == '0 && pin_oe == '0 && pin_out == '0));

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_dir |=> pin_oe == $past(bus_wdata[NLINES-1:0]));

  // R2
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_dout |=> $stable(pin_out));

  // R6
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_sh == '0) |=> (irq_out == '0));

  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_line |=> ((bus_rdata & ~LMASK) == 32'd0));

  // R9
  gap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_gap |=> (bus_rdata == 32'd0));

endmodule

bind gpio_irq_port gpio_irq_port_chk #(
  .NLINES(NLINES), .NIRQ(NIRQ), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
  .pin_oe(pin_oe), .irq_out(irq_out)
);

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb_top;

  localparam int CLK_P = 10;
  localparam int NL    = 20;
  localparam int NI    = 3;
  localparam int AW    = 8;

  localparam int K_IRQ  = 0;
  localparam int K_RD   = 1;
  localparam int K_DOUT = 2;
  localparam int K_OE   = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] pin_in = '0;
  logic [NL-1:0] pin_out, pin_oe;
  logic [NI-1:0] irq_out;

  always #(CLK_P/2) clk = ~clk;

  gpio_irq_port #(.NLINES(NL), .NIRQ(NI), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  typedef struct {
    int          due;
    int          kind;
    logic [31:0] val;
    string       req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // driver side: push an expectation a number of cycles ahead
  task automatic exp_at(input int dly, input int kind, input logic [31:0] v,
                        input string req);
    item_t it;
    it.due = cyc + dly; it.kind = kind; it.val = v; it.req = req;
    q.push_back(it);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string req);
    exp_at(1, K_RD, e, req);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] actual(input int kind);
    case (kind)
      K_IRQ:  return 32'(irq_out);
      K_RD:   return bus_rdata;
      K_DOUT: return 32'(pin_out);
      default: return 32'(pin_oe);
    endcase
  endfunction

  // monitor: compare due items a quarter period after the edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].due == cyc) begin
          total++;
          if (actual(q[i].kind) !== q[i].val) begin
            bad++;
            $display("FAIL %s kind=%0d cyc=%0d actual=%h expected=%h",
                     q[i].req, q[i].kind, cyc, actual(q[i].kind), q[i].val);
          end
          q.delete(i);
        end else if (q[i].due < cyc) begin
          total++; bad++;
          $display("FAIL %s stale item actual=none expected=%h", q[i].req, q[i].val);
          q.delete(i);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state
    exp_at(1, K_IRQ, 0, "R1");
    exp_at(1, K_OE, 0, "R1");
    exp_at(1, K_DOUT, 0, "R1");
    idle(1);
    rd(8'h04, 0, "R1");
    rd(8'h0C, 0, "R1");
    rd(8'h20, 0, "R1");

    // R2 output and direction
    exp_at(1, K_DOUT, 32'h5A5A5, "R2");
    wr(8'h04, 32'hA5A5A5A5);
    exp_at(1, K_OE, 32'hFF0F0, "R2");
    wr(8'h08, 32'hFFFFF0F0);
    exp_at(1, K_DOUT, 32'h5A5A5, "R2");
    idle(1);
    rd(8'h04, 32'h5A5A5, "R2");

    // R3 synchronised input, write ignored
    pin_in = 20'h12345;
    idle(2);
    rd(8'h00, 32'h12345, "R3");
    wr(8'h00, 32'hFFFFFFFF);
    rd(8'h00, 32'h12345, "R3");
    pin_in = '0;
    idle(4);

    // routing map (R7): l0->0 l1->1 l2->2 l3->3(unrouted) l4->0 l5->1 l6->7 l7->FF, l19->1
    wr(8'h20, 32'h03020100);
    wr(8'h24, 32'hFF070100);
    wr(8'h30, 32'h01000000);

    // R4 active-high level on line 1
    wr(8'h10, 32'h2);
    exp_at(2, K_IRQ, 0, "R4");
    wr(8'h0C, 32'h2);
    pin_in = 20'h2;
    exp_at(3, K_IRQ, 3'b010, "R4");
    exp_at(5, K_IRQ, 3'b010, "R4");
    idle(6);
    pin_in = '0;
    exp_at(3, K_IRQ, 0, "R4");
    idle(4);
    // R4 active-low level on line 2
    exp_at(2, K_IRQ, 3'b100, "R4");
    wr(8'h0C, 32'h6);
    idle(2);
    pin_in = 20'h4;
    exp_at(3, K_IRQ, 0, "R4");
    idle(4);
    wr(8'h0C, 0);
    pin_in = '0;
    idle(4);

    // R5 rising edge on line 0
    wr(8'h10, 32'h1);
    wr(8'h14, 32'h1);
    exp_at(2, K_IRQ, 0, "R5");
    wr(8'h0C, 32'h1);
    idle(2);
    pin_in = 20'h1;
    exp_at(3, K_IRQ, 3'b001, "R5");
    exp_at(4, K_IRQ, 0, "R5");
    exp_at(6, K_IRQ, 0, "R5");
    idle(7);
    // R5 falling edge on line 0
    exp_at(2, K_IRQ, 0, "R5");
    wr(8'h10, 32'h0);
    idle(2);
    pin_in = '0;
    exp_at(3, K_IRQ, 3'b001, "R5");
    exp_at(4, K_IRQ, 0, "R5");
    idle(6);
    pin_in = 20'h1;
    exp_at(3, K_IRQ, 0, "R5");
    exp_at(4, K_IRQ, 0, "R5");
    idle(6);

    // R6 mask cleared blocks the line
    wr(8'h0C, 0);
    wr(8'h10, 32'h1);
    pin_in = '0;
    idle(4);
    pin_in = 20'h1;
    exp_at(3, K_IRQ, 0, "R6");
    exp_at(4, K_IRQ, 0, "R6");
    idle(6);
    pin_in = '0;
    idle(4);

    // R8 two rising edges sharing output 0
    wr(8'h10, 32'h11);
    wr(8'h14, 32'h11);
    wr(8'h0C, 32'h11);
    idle(2);
    pin_in = 20'h11;
    exp_at(3, K_IRQ, 3'b001, "R8");
    exp_at(4, K_IRQ, 0, "R8");
    idle(6);
    pin_in = '0;
    idle(4);
    // R8 edge on line 0 plus level on line 1 in the same cycle
    wr(8'h10, 32'h13);
    wr(8'h0C, 32'h13);
    idle(2);
    pin_in = 20'h3;
    exp_at(3, K_IRQ, 3'b011, "R8");
    exp_at(4, K_IRQ, 3'b010, "R8");
    idle(6);
    pin_in = '0;
    idle(4);
    wr(8'h0C, 0);

    // R7 unrouted indices, remap, last line
    wr(8'h10, 32'h80048);
    wr(8'h14, 32'h0);
    exp_at(2, K_IRQ, 0, "R7");
    wr(8'h0C, 32'h80048);
    idle(2);
    pin_in = 20'h48;
    exp_at(3, K_IRQ, 0, "R7");
    exp_at(5, K_IRQ, 0, "R7");
    idle(6);
    exp_at(2, K_IRQ, 3'b100, "R7");
    wr(8'h20, 32'h02020100);
    idle(3);
    pin_in = 20'h80048;
    exp_at(3, K_IRQ, 3'b110, "R7");
    idle(5);
    pin_in = '0;
    idle(4);
    wr(8'h0C, 0);

    // R9 read-back and unused space
    rd(8'h10, 32'h80048, "R9");
    rd(8'h14, 0, "R9");
    rd(8'h24, 32'hFF070100, "R9");
    rd(8'h30, 32'h01000000, "R9");
    rd(8'h34, 0, "R9");
    rd(8'h18, 0, "R9");
    rd(8'h1C, 0, "R9");
    wr(8'h10, 32'hFFFFFFFF);
    rd(8'h10, 32'h000FFFFF, "R9");

    wait (q.size() == 0);
    idle(3);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule